// File: doc/BRIEF.md
# Interrupt Status and Enable Register Pair

This block keeps the interrupt state of a serial link controller behind an 8-bit register bus. Five event sources report through single-cycle pulse inputs: transmit completion, receive completion, transmit FIFO underflow, receive FIFO overflow, and detection of a serial gap on the line. Each pulse sets a sticky status bit. Software clears a status bit by writing a one to it. A second register holds one enable bit per source.

A single level-sensitive interrupt output is high while any status bit is set and its enable bit is also set. The two registers use one common layout. Sources occupy bits 7 down to 3. Bits 2:0 have no storage and always read as ones. A transmit-completion pulse counts only when the finished descriptor asked for a completion interrupt. That request arrives as a qualifier that is valid in the same cycle as the pulse.

Top module: `irq_status_pair`

## Requirements
- R1: After reset, every status and enable bit is clear. Reading offset 0x0C or 0x0D returns 0x07, and `irq_o` is low.
- R2: A one-cycle event pulse sets its status bit at the next clock edge. The bit positions are: transmit done bit 7, receive done bit 6, transmit underflow bit 5, receive overflow bit 4, serial gap bit 3. The status register sits at offset 0x0C.
- R3: Bits 2:0 of offsets 0x0C and 0x0D always read as 1. Writes to these bits are ignored.
- R4: A write to offset 0x0D loads bits 7:3 into the enable bits. A 1 enables the source at that position and a 0 disables it.
- R5: A write to offset 0x0C clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R6: A transmit-done pulse sets bit 7 only if `tx_done_req_i` is high in the same cycle. Otherwise the pulse has no effect.
- R7: `irq_o` is high exactly when the bitwise AND of the status register, the enable register and 0xF8 is nonzero. It follows the registers with no added delay.
- R8: When an event pulse and a clearing write to the same status bit fall in one cycle, the bit ends up set.
- R9: Reads of any offset other than 0x0C and 0x0D return 0x00. Writes to those other offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 5 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on the offset |
| ev_tx_done_i | input | 1 | Transmit descriptor finished (pulse) |
| tx_done_req_i | input | 1 | Finished descriptor requested a done interrupt |
| ev_rx_done_i | input | 1 | Receive completed (pulse) |
| ev_tx_under_i | input | 1 | Transmit FIFO underflow (pulse) |
| ev_rx_over_i | input | 1 | Receive FIFO overflow (pulse) |
| ev_gap_i | input | 1 | Serial gap received (pulse) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The main sweep covers all 32 enable patterns. For each one it raises all 32 combinations of simultaneous event pulses and compares the interrupt line and the status readback against arithmetic on the two masks. This separates a wrong bit position, a missing enable gate and an OR taken over unmasked status. Directed patterns then handle the rest. A partial clear mask shows that zero bits are left alone. A transmit-done pulse without its qualifier must leave the status unchanged. An event that lands together with its own clear must leave the bit set. Writes to unused offsets must leave both registers intact.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
    localparam int SRC_N  = 5;
    localparam int DATA_W = 8;
    localparam int LOW_W  = DATA_W - SRC_N;

    // source index inside the event vector; status bit = LOW_W + index
    localparam int IDX_GAP      = 0;
    localparam int IDX_RX_OVER  = 1;
    localparam int IDX_TX_UNDER = 2;
    localparam int IDX_RX_DONE  = 3;
    localparam int IDX_TX_DONE  = 4;

    typedef struct packed {
        logic st;
        logic en;
    } cell_t;
endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
    import irq_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clr_i,
    input  logic en_we_i,
    input  logic en_wd_i,
    output logic st_o,
    output logic en_o
);
    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clr_i)    cell_d.st = 1'b0;
        if (event_i)  cell_d.st = 1'b1;   // event wins over a clear
        if (en_we_i)  cell_d.en = en_wd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign st_o = cell_q.st;
    assign en_o = cell_q.en;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> st_o); // R2
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && clr_i) |=> st_o); // R8
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !event_i) |=> !st_o); // R5
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !event_i) |=> $stable(st_o)); // R5
    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(en_wd_i))); // R4
    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_o)); // R4
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pair_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int STAT_ADDR = 12,
    parameter int EN_ADDR   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  st_i,
    input  logic [SRC_N-1:0]  en_i,
    output logic [SRC_N-1:0]  clr_o,
    output logic              en_we_o,
    output logic [SRC_N-1:0]  en_wd_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
    localparam logic [LOW_W-1:0]  ONES   = '1;

    logic hit_st, hit_en;

    always_comb begin
        hit_st  = (addr_i == A_STAT);
        hit_en  = (addr_i == A_EN);
        clr_o   = (wr_i && hit_st) ? wdata_i[DATA_W-1:LOW_W] : '0;
        en_we_o = wr_i && hit_en;
        en_wd_o = wdata_i[DATA_W-1:LOW_W];
        if (hit_st)      rdata_o = {st_i, ONES};
        else if (hit_en) rdata_o = {en_i, ONES};
        else             rdata_o = '0;
    end

    AST_LOW_BITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_STAT || addr_i == A_EN) |-> (rdata_o[LOW_W-1:0] == ONES)); // R3
    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != A_STAT && addr_i != A_EN) |-> (rdata_o == '0)); // R9
endmodule

// File: rtl/irq_status_pair.sv
module irq_status_pair
    import irq_pair_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int STAT_ADDR = 12,
    parameter int EN_ADDR   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              ev_tx_done_i,
    input  logic              tx_done_req_i,
    input  logic              ev_rx_done_i,
    input  logic              ev_tx_under_i,
    input  logic              ev_rx_over_i,
    input  logic              ev_gap_i,
    output logic              irq_o
);
    logic [SRC_N-1:0] evt, clr, st, en, en_wd;
    logic             en_we;

    always_comb begin
        evt               = '0;
        evt[IDX_TX_DONE]  = ev_tx_done_i && tx_done_req_i;
        evt[IDX_RX_DONE]  = ev_rx_done_i;
        evt[IDX_TX_UNDER] = ev_tx_under_i;
        evt[IDX_RX_OVER]  = ev_rx_over_i;
        evt[IDX_GAP]      = ev_gap_i;
    end

    irq_bus_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .st_i(st), .en_i(en),
        .clr_o(clr), .en_we_o(en_we), .en_wd_o(en_wd), .rdata_o(bus_rdata_o)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_cell
        irq_bit_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .event_i(evt[g]), .clr_i(clr[g]),
            .en_we_i(en_we), .en_wd_i(en_wd[g]),
            .st_o(st[g]), .en_o(en[g])
        );
    end

    assign irq_o = |(st & en);

    AST_TXDONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!st[IDX_TX_DONE] && ev_tx_done_i && !tx_done_req_i) |=> !st[IDX_TX_DONE]); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o); // R7
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == '0) |-> !irq_o); // R7
endmodule

// File: tb/sim_irq_status_pair.sv
`timescale 1ns/1ps
module sim_irq_status_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_txd = 0, txreq = 0, ev_rxd = 0, ev_txu = 0, ev_rxo = 0, ev_gap = 0;
    logic       irq;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_status_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .ev_tx_done_i(ev_txd), .tx_done_req_i(txreq), .ev_rx_done_i(ev_rxd),
        .ev_tx_under_i(ev_txu), .ev_rx_over_i(ev_rxo), .ev_gap_i(ev_gap),
        .irq_o(irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_wr = 0; bus_addr = a; #1; d = bus_rdata;
    endtask

    // drive event pulses for mask m (bit4=tx done ... bit0=gap) during the next edge
    task automatic set_ev(input logic [4:0] m, input logic req);
        ev_txd = m[4]; txreq = req; ev_rxd = m[3]; ev_txu = m[2]; ev_rxo = m[1]; ev_gap = m[0];
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(); tick();
        rst_n = 1;
        #1;
        // R1 reset state
        rd(5'h0C, d); chk("R1 status reset", d, 8'h07);
        rd(5'h0D, d); chk("R1 enable reset", d, 8'h07);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);

        // R2 R4 R7 sweep over enable x event patterns
        for (int e = 0; e < 32; e++) begin
            wr(5'h0D, {e[4:0], 3'b000});
            rd(5'h0D, d); chk("R4 enable readback", d, {e[4:0], 3'b111});
            for (int s = 0; s < 32; s++) begin
                set_ev(s[4:0], 1'b1);
                tick();
                set_ev(5'd0, 1'b0);
                #1;
                chk("R7 irq level", {7'b0, irq}, {7'b0, |(s[4:0] & e[4:0])});
                rd(5'h0C, d); chk("R2 status bits", d, {s[4:0], 3'b111});
                wr(5'h0C, 8'hFF);
                rd(5'h0C, d); chk("R5 clear all", d, 8'h07);
            end
        end

        // R3 low bits ignore writes
        wr(5'h0D, 8'h00); rd(5'h0D, d); chk("R3 enable low bits", d, 8'h07);
        wr(5'h0D, 8'hFF); rd(5'h0D, d); chk("R3 enable all", d, 8'hFF);

        // R5 partial clear
        set_ev(5'b11111, 1'b1); tick(); set_ev(5'd0, 1'b0);
        wr(5'h0C, 8'hA7);
        rd(5'h0C, d); chk("R5 partial clear", d, 8'h5F);
        chk("R7 irq still set", {7'b0, irq}, 8'h01);
        wr(5'h0C, 8'h00);
        rd(5'h0C, d); chk("R5 zero write keeps", d, 8'h5F);
        wr(5'h0C, 8'hFF);
        chk("R7 irq cleared", {7'b0, irq}, 8'h00);

        // R6 transmit done without request
        set_ev(5'b10000, 1'b0); tick(); set_ev(5'd0, 1'b0); #1;
        rd(5'h0C, d); chk("R6 tx done unqualified", d, 8'h07);
        chk("R6 irq stays low", {7'b0, irq}, 8'h00);
        txreq = 1; tick(); txreq = 0; #1;
        rd(5'h0C, d); chk("R6 req alone", d, 8'h07);
        set_ev(5'b10000, 1'b1); tick(); set_ev(5'd0, 1'b0); #1;
        rd(5'h0C, d); chk("R6 tx done qualified", d, 8'h87);

        // R8 event and clear in the same cycle
        set_ev(5'b01000, 1'b0);
        wr(5'h0C, 8'hC0);
        set_ev(5'd0, 1'b0);
        rd(5'h0C, d); chk("R8 event beats clear", d, 8'h47);

        // R9 other offsets
        wr(5'h0E, 8'hFF);
        rd(5'h0C, d); chk("R9 status untouched", d, 8'h47);
        rd(5'h0D, d); chk("R9 enable untouched", d, 8'hFF);
        rd(5'h0E, d); chk("R9 other read zero", d, 8'h00);
        rd(5'h00, d); chk("R9 offset zero read", d, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule